// File: doc/BRIEF.md
# Transposed-Access Tile Video RAM

This block holds the tile map and the matching colour map of a character display. Each map holds one byte for every cell of a square grid, 32 by 32 cells with the default parameters. The CPU reaches either map through two windows. The direct window takes a row-major cell address. The transposed window swaps the row and column fields, so a run of consecutive CPU addresses walks down one column of the grid.

Row 0 of the transposed space is the sprite attribute area. Through the direct window, that same area is the leftmost column of the tile map. A second read-only port serves the display scan. It always uses row-major addressing and runs alongside the CPU port without stalling it.

The CPU bus is synchronous. An address decoder outside the block raises one of four selects: tile direct, colour direct, tile transposed or colour transposed. Read data appears one cycle after the address. A write lands on the clock edge where the write strobe and exactly one select are both high.

Top module: `tile_xram`

## Requirements
- R1: With only `sel_tile` or only `sel_attr` high, `cpu_addr` is used as is. Bits [9:5] are the row and bits [4:0] are the column. A write stores `cpu_wdata` in that cell of the tile map (`sel_tile`) or of the colour map (`sel_attr`), and a read returns the byte held there.
- R2: With only `sel_tile_x` or only `sel_attr_x` high, the access goes to the cell {cpu_addr[4:0], cpu_addr[9:5]} of the tile map or of the colour map. It is the same physical storage that the direct window reaches.
- R3: The tile map and the colour map are separate. A write to one leaves every byte of the other unchanged.
- R4: `cpu_rdata` shows the addressed byte in the cycle after the address and select were sampled, and not earlier.
- R5: When no select is high, a write has no effect and `cpu_rdata` is 0 in the next cycle.
- R6: When more than one select is high, the access is ignored. Nothing is written and `cpu_rdata` is 0 in the next cycle.
- R7: A CPU access to a cell returns the content the cell held before any write made in that same cycle. A read in the cycle after a write returns the new byte.
- R8: `scan_tile` and `scan_attr` show the tile and colour bytes at the row-major `scan_addr` one cycle later. These reads are independent of CPU activity, and a CPU write in the same cycle is seen only from the next cycle on.
- R9: While `rst_n` is low, `cpu_rdata`, `scan_tile` and `scan_attr` are 0.
- R10: Transposed addresses 0 to 31 (row 0) map to column 0 of the direct view. Transposed address i is the same cell as direct address i*32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_tile | input | 1 | Tile map, direct window select |
| sel_attr | input | 1 | Colour map, direct window select |
| sel_tile_x | input | 1 | Tile map, transposed window select |
| sel_attr_x | input | 1 | Colour map, transposed window select |
| cpu_addr | input | 10 | CPU cell address within the window |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle latency |
| scan_addr | input | 10 | Display scan row-major address |
| scan_tile | output | 8 | Tile byte at the scan address |
| scan_attr | output | 8 | Colour byte at the scan address |

## Verification
Every result is due exactly one clock edge after its inputs are sampled. This covers the CPU read byte, the zero returned for an idle or conflicting select, and both scan bytes. The bench drives each access at a falling edge. It works out the expected bytes from its own copy of both maps as they stood before that cycle's write, and compares them shortly after the next rising edge. For R4, it also confirms that the output has not yet changed before that edge.

// File: rtl/tile_xram.sv
module tile_xram #(
  parameter int COORD_W = 5,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * COORD_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_tile,
  input  logic              sel_attr,
  input  logic              sel_tile_x,
  input  logic              sel_attr_x,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [DATA_W-1:0] scan_tile,
  output logic [DATA_W-1:0] scan_attr
);

  logic [DATA_W-1:0] tile_mem [DEPTH];
  logic [DATA_W-1:0] attr_mem [DEPTH];

  wire [3:0] sels = {sel_attr_x, sel_tile_x, sel_attr, sel_tile};
  wire       single = $onehot(sels);
  wire       mirror = sel_tile_x | sel_attr_x;
  wire       hit_tile = single & (sel_tile | sel_tile_x);
  wire       hit_attr = single & (sel_attr | sel_attr_x);

  wire [ADDR_W-1:0] swapped = {cpu_addr[COORD_W-1:0], cpu_addr[ADDR_W-1:COORD_W]};
  wire [ADDR_W-1:0] phys    = mirror ? swapped : cpu_addr;

  always_ff @(posedge clk) begin
    if (hit_tile && cpu_we) tile_mem[phys] <= cpu_wdata;
    if (hit_attr && cpu_we) attr_mem[phys] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      scan_tile <= '0;
      scan_attr <= '0;
    end else begin
      if (hit_tile)      cpu_rdata <= tile_mem[phys];
      else if (hit_attr) cpu_rdata <= attr_mem[phys];
      else               cpu_rdata <= '0;
      scan_tile <= tile_mem[scan_addr];
      scan_attr <= attr_mem[scan_addr];
    end
  end

endmodule

// File: rtl/tile_xram_chk.sv
module tile_xram_chk #(
  parameter int COORD_W = 5,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * COORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_tile,
  input logic              sel_attr,
  input logic              sel_tile_x,
  input logic              sel_attr_x,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata
);

  wire [3:0] sels = {sel_attr_x, sel_tile_x, sel_attr, sel_tile};
  wire only_tile   = (sels == 4'b0001);
  wire only_tile_x = (sels == 4'b0100);

  logic              prev_w, prev_xw;
  logic [ADDR_W-1:0] prev_a, prev_at;
  logic [DATA_W-1:0] prev_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_w  <= 1'b0;
      prev_xw <= 1'b0;
      prev_a  <= '0;
      prev_at <= '0;
      prev_d  <= '0;
    end else begin
      prev_w  <= only_tile & cpu_we;
      prev_xw <= only_tile_x & cpu_we;
      prev_a  <= cpu_addr;
      prev_at <= {cpu_addr[COORD_W-1:0], cpu_addr[ADDR_W-1:COORD_W]};
      prev_d  <= cpu_wdata;
    end
  end

  assert_reset_zero_R9: assert property (@(posedge clk)
    !rst_n |=> cpu_rdata == '0);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sels == 4'b0000) |=> cpu_rdata == '0);

  assert_conflict_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sels) > 1) |=> cpu_rdata == '0);

  assert_write_then_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_w && only_tile && cpu_addr == prev_a) |=> cpu_rdata == $past(prev_d));

  assert_transpose_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_xw && only_tile && cpu_addr == prev_at) |=> cpu_rdata == $past(prev_d));

endmodule

bind tile_xram tile_xram_chk #(.COORD_W(COORD_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tile_xram_tb.sv
module tile_xram_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_tile = 0, sel_attr = 0, sel_tile_x = 0, sel_attr_x = 0;
  logic [9:0] cpu_addr = '0, scan_addr = '0;
  logic cpu_we = 0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, scan_tile, scan_attr;

  always #2 clk = ~clk;

  tile_xram u_dut (.*);

  logic [7:0] vm [1024];
  logic [7:0] cm [1024];
  int errors = 0, checks = 0;
  bit chk_en = 0;

  function automatic logic [9:0] phys(input logic [3:0] s, input logic [9:0] a);
    return (s[2] | s[3]) ? {a[4:0], a[9:5]} : a;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [3:0] s, input logic [9:0] a, input logic we,
                       input logic [7:0] d, input logic [9:0] sa, input string tag);
    logic [7:0] er, et, ec;
    logic [9:0] p;
    string t;
    @(negedge clk);
    {sel_attr_x, sel_tile_x, sel_attr, sel_tile} = s;
    cpu_addr = a; cpu_we = we; cpu_wdata = d; scan_addr = sa;
    p = phys(s, a);
    if ($countones(s) == 1) er = (s[0] | s[2]) ? vm[p] : cm[p];
    else er = 8'h00;
    et = vm[sa]; ec = cm[sa];
    @(posedge clk); #1;
    if (tag != "") t = tag;
    else if (s == 4'b0000) t = "R5";
    else if ($countones(s) > 1) t = "R6";
    else if (s[2] | s[3]) t = "R2";
    else t = "R1";
    if (chk_en) begin
      check(t, cpu_rdata, er);
      check("R8 tile", scan_tile, et);
      check("R8 attr", scan_attr, ec);
    end
    if ($countones(s) == 1 && we) begin
      if (s[0] | s[2]) vm[p] = d; else cm[p] = d;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R9 rdata", cpu_rdata, 8'h00);
    check("R9 scan_tile", scan_tile, 8'h00);
    check("R9 scan_attr", scan_attr, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 1024; i++) begin
      cycle(4'b0001, 10'(i), 1'b1, 8'($urandom), 10'(i), "");
      cycle(4'b0010, 10'(i), 1'b1, 8'($urandom), 10'(i), "");
    end
    chk_en = 1;

    for (int i = 0; i < 32; i++)
      cycle(4'b0100, 10'(i), 1'b1, 8'(8'h40 + i), 10'(i * 32), "R10");
    for (int i = 0; i < 32; i++)
      cycle(4'b0001, 10'(i * 32), 1'b0, 8'h00, 10'(i * 32), "R10");

    cycle(4'b0001, 10'h155, 1'b1, 8'hA5, 10'h155, "R7");
    cycle(4'b0001, 10'h155, 1'b1, 8'h3C, 10'h155, "R7");
    cycle(4'b0001, 10'h155, 1'b0, 8'h00, 10'h155, "R7");

    cycle(4'b0010, 10'h0AB, 1'b1, 8'h77, 10'h0AB, "R3");
    cycle(4'b0001, 10'h0AB, 1'b1, 8'h11, 10'h0AB, "R3");
    cycle(4'b0010, 10'h0AB, 1'b0, 8'h00, 10'h0AB, "R3");

    cycle(4'b0000, 10'h0AB, 1'b1, 8'hEE, 10'h0AB, "R5");
    cycle(4'b0001, 10'h0AB, 1'b0, 8'h00, 10'h0AB, "R5");
    cycle(4'b0101, 10'h0AB, 1'b1, 8'hDD, 10'h0AB, "R6");
    cycle(4'b0001, 10'h0AB, 1'b0, 8'h00, 10'h0AB, "R6");

    cycle(4'b0001, 10'h0AB, 1'b0, 8'h00, 10'h0AB, "R4");
    @(negedge clk);
    sel_tile = 1'b0; sel_attr = 1'b1; cpu_we = 1'b0;
    #1;
    check("R4 early", cpu_rdata, vm[10'h0AB]);
    @(posedge clk); #1;
    check("R4", cpu_rdata, cm[10'h0AB]);

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] s;
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) s = 4'b0000;
      else if (r == 1) s = 4'($urandom_range(3, 15)) | 4'b0011;
      else s = 4'b0001 << $urandom_range(0, 3);
      cycle(s, 10'($urandom), 1'($urandom), 8'($urandom), 10'($urandom), "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule